// File: doc/BRIEF.md
# Dual-Port Synchronous Burst RAM

A true dual-port synchronous memory with two fully independent ports, A and B. Each port runs on its own clock and reset, and each can read or write any word at any time. Nothing arbitrates between the ports and no port ever waits. Each port registers its address source, control and write data on the rising edge of its clock. The access then takes place on the next edge of that clock.

Each port holds a burst pointer, which is the address it uses for every access. On each edge the pointer can be cleared, loaded from the external address, stepped by one, or held, so a burst needs only one address transfer. A port is selected only when both of its selects are high. Writes are masked in two lanes, an upper lane and a lower lane. Read data leaves either after one output register (flow-through) or after a second register (pipelined), chosen per port by a static pin. An output-enable pin gates the valid flag only.

The word count is set by `ADDR_W`; the default is 10, and 16 gives 65536 words. The word width is set by `DATA_W`, default 18. The lower lane holds `DATA_W/2` bits and the upper lane holds the rest.

Top module: `dual_burst_ram`

## Requirements
- R1: While reset is high, and on the first edge after it, `x_rvalid` is 0, `x_rdata` is 0 and the burst pointer is 0. The words in the array are not cleared.
- R2: With `x_pipe`=0, a read sampled at edge k drives `x_rdata` and `x_rvalid` after edge k+1.
- R3: With `x_pipe`=1, a read sampled at edge k drives `x_rdata` and `x_rvalid` after edge k+2. `x_pipe` changes only while the port is in reset.
- R4: A port is selected only when `x_cs0` and `x_cs1` are both 1. A request sampled with the port deselected writes nothing and never raises `x_rvalid`.
- R5: On a write, `x_hi_en` enables bits [DATA_W-1:DATA_W/2] and `x_lo_en` enables bits [DATA_W/2-1:0]. Only the enabled lanes of the word change.
- R6: On a read, a lane whose enable is 0 returns zeros. `x_rvalid` is still raised.
- R7: On each edge the pointer becomes 0 if `x_clr`=1. Otherwise it becomes `x_addr` if `x_ld`=1, otherwise pointer+1 if `x_inc`=1, otherwise it holds. The new value is the address of the access sampled at that edge. The pointer updates whether or not the port is selected.
- R8: Stepping the pointer from the last word wraps it to word 0.
- R9: Data written by either port can be read by either port from the next edge of the reading port's clock on. A read of a word being written by the other port on the same edge may return the old or the new data. If both ports write the same word on the same edge, the result is undefined.
- R10: `x_rvalid` is the staged valid ANDed with `x_oe` as sampled at the latest edge. `x_oe` never changes `x_rdata` or the staged data.
- R11: A write request never raises `x_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A asynchronous reset, active high |
| a_cs0 | input | 1 | Port A select, first of two |
| a_cs1 | input | 1 | Port A select, second of two |
| a_hi_en | input | 1 | Port A upper-lane enable |
| a_lo_en | input | 1 | Port A lower-lane enable |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_oe | input | 1 | Port A output enable for the valid flag |
| a_pipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_ld | input | 1 | Port A pointer load strobe |
| a_inc | input | 1 | Port A pointer step enable |
| a_clr | input | 1 | Port A pointer clear |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B asynchronous reset, active high |
| b_cs0 | input | 1 | Port B select, first of two |
| b_cs1 | input | 1 | Port B select, second of two |
| b_hi_en | input | 1 | Port B upper-lane enable |
| b_lo_en | input | 1 | Port B lower-lane enable |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_oe | input | 1 | Port B output enable for the valid flag |
| b_pipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_ld | input | 1 | Port B pointer load strobe |
| b_inc | input | 1 | Port B pointer step enable |
| b_clr | input | 1 | Port B pointer clear |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The bench builds the block with `ADDR_W`=6 and `DATA_W`=18. With only 64 words, random addresses from the two ports meet often, so reads of data the other port wrote, and same-edge collisions that the bench must tolerate, come up many times. The last word is reachable directly, so the wrap from 63 to 0 can be driven. The 18-bit word gives two 9-bit lanes, so upper-only and lower-only writes and reads produce distinct patterns. Each port runs once in flow-through mode and once in pipelined mode, so both latencies are covered on both ports.

// File: rtl/dual_burst_ram.sv
module dual_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              a_clk,
  input  logic              a_rst,
  input  logic              a_cs0,
  input  logic              a_cs1,
  input  logic              a_hi_en,
  input  logic              a_lo_en,
  input  logic              a_wr,
  input  logic              a_oe,
  input  logic              a_pipe,
  input  logic              a_ld,
  input  logic              a_inc,
  input  logic              a_clr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_clk,
  input  logic              b_rst,
  input  logic              b_cs0,
  input  logic              b_cs1,
  input  logic              b_hi_en,
  input  logic              b_lo_en,
  input  logic              b_wr,
  input  logic              b_oe,
  input  logic              b_pipe,
  input  logic              b_ld,
  input  logic              b_inc,
  input  logic              b_clr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LO_W  = DATA_W / 2;
  localparam int HI_W  = DATA_W - LO_W;

  // Each port owns one bank; the stored word is the XOR of both banks.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  function automatic logic [ADDR_W-1:0] ptr_next(input logic clr, input logic ld,
      input logic inc, input logic [ADDR_W-1:0] ext, input logic [ADDR_W-1:0] cur);
    if (clr)      return '0;
    else if (ld)  return ext;
    else if (inc) return cur + 1'b1;
    else          return cur;
  endfunction

  function automatic logic [DATA_W-1:0] lanes(input logic hi, input logic lo);
    return {{HI_W{hi}}, {LO_W{lo}}};
  endfunction

  // ---------------- port A ----------------
  logic [ADDR_W-1:0] a_ptr;
  logic              a_go, a_wq, a_hq, a_lq, a_oq, a_v1, a_v2;
  logic [DATA_W-1:0] a_dq, a_q1, a_q2, a_word, a_msk;
  logic              a_sel;

  assign a_sel  = a_cs0 & a_cs1;
  assign a_msk  = lanes(a_hq, a_lq);
  assign a_word = bank_a[a_ptr] ^ bank_b[a_ptr];

  always_ff @(posedge a_clk or posedge a_rst) begin
    if (a_rst) begin
      a_ptr <= '0;
      a_go  <= 1'b0;
      a_wq  <= 1'b0;
      a_hq  <= 1'b0;
      a_lq  <= 1'b0;
      a_oq  <= 1'b0;
      a_dq  <= '0;
      a_v1  <= 1'b0;
      a_v2  <= 1'b0;
      a_q1  <= '0;
      a_q2  <= '0;
    end else begin
      a_ptr <= ptr_next(a_clr, a_ld, a_inc, a_addr, a_ptr);
      a_go  <= a_sel;
      a_wq  <= a_wr;
      a_hq  <= a_hi_en;
      a_lq  <= a_lo_en;
      a_oq  <= a_oe;
      a_dq  <= a_wdata;
      a_v1  <= a_go & ~a_wq;
      if (a_go && !a_wq) a_q1 <= a_word & a_msk;
      a_v2  <= a_v1;
      a_q2  <= a_q1;
    end
  end

  always_ff @(posedge a_clk) begin
    if (a_go && a_wq)
      bank_a[a_ptr] <= (bank_a[a_ptr] & ~a_msk) | ((a_dq ^ bank_b[a_ptr]) & a_msk);
  end

  assign a_rdata  = a_pipe ? a_q2 : a_q1;
  assign a_rvalid = (a_pipe ? a_v2 : a_v1) & a_oq;

  // ---------------- port B ----------------
  logic [ADDR_W-1:0] b_ptr;
  logic              b_go, b_wq, b_hq, b_lq, b_oq, b_v1, b_v2;
  logic [DATA_W-1:0] b_dq, b_q1, b_q2, b_word, b_msk;
  logic              b_sel;

  assign b_sel  = b_cs0 & b_cs1;
  assign b_msk  = lanes(b_hq, b_lq);
  assign b_word = bank_a[b_ptr] ^ bank_b[b_ptr];

  always_ff @(posedge b_clk or posedge b_rst) begin
    if (b_rst) begin
      b_ptr <= '0;
      b_go  <= 1'b0;
      b_wq  <= 1'b0;
      b_hq  <= 1'b0;
      b_lq  <= 1'b0;
      b_oq  <= 1'b0;
      b_dq  <= '0;
      b_v1  <= 1'b0;
      b_v2  <= 1'b0;
      b_q1  <= '0;
      b_q2  <= '0;
    end else begin
      b_ptr <= ptr_next(b_clr, b_ld, b_inc, b_addr, b_ptr);
      b_go  <= b_sel;
      b_wq  <= b_wr;
      b_hq  <= b_hi_en;
      b_lq  <= b_lo_en;
      b_oq  <= b_oe;
      b_dq  <= b_wdata;
      b_v1  <= b_go & ~b_wq;
      if (b_go && !b_wq) b_q1 <= b_word & b_msk;
      b_v2  <= b_v1;
      b_q2  <= b_q1;
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_go && b_wq)
      bank_b[b_ptr] <= (bank_b[b_ptr] & ~b_msk) | ((b_dq ^ bank_a[b_ptr]) & b_msk);
  end

  assign b_rdata  = b_pipe ? b_q2 : b_q1;
  assign b_rvalid = (b_pipe ? b_v2 : b_v1) & b_oq;

  // ---------------- assertions ----------------
  p_clr_zero_r7: assert property (@(posedge a_clk) disable iff (a_rst)
    a_clr |=> a_ptr == '0);
  p_load_ext_r7: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_clr && a_ld |=> a_ptr == $past(a_addr));
  p_step_wrap_r8: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_clr && !a_ld && a_inc |=> a_ptr == ADDR_W'($past(a_ptr) + 1'b1));
  p_hold_r7: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_clr && !a_ld && !a_inc |=> $stable(a_ptr));
  p_flow_lat_r2: assert property (@(posedge a_clk) disable iff (a_rst)
    (!a_pipe && a_sel && !a_wr) ##1 a_oe |=> a_rvalid);
  p_pipe_lat_r3: assert property (@(posedge a_clk) disable iff (a_rst)
    (a_pipe && a_sel && !a_wr) ##1 1'b1 ##1 a_oe |=> a_rvalid);
  p_desel_quiet_r4: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_pipe && !a_sel |=> ##1 !a_rvalid);
  p_write_quiet_r11: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_pipe && a_sel && a_wr |=> ##1 !a_rvalid);
  p_oe_gate_r10: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_oe |=> !a_rvalid);
  p_hi_lane_zero_r6: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_pipe && a_sel && !a_wr && !a_hi_en |=> ##1 a_rdata[DATA_W-1:LO_W] == '0);

  p_b_clr_zero_r7: assert property (@(posedge b_clk) disable iff (b_rst)
    b_clr |=> b_ptr == '0);
  p_b_flow_lat_r2: assert property (@(posedge b_clk) disable iff (b_rst)
    (!b_pipe && b_sel && !b_wr) ##1 b_oe |=> b_rvalid);
  p_b_pipe_lat_r3: assert property (@(posedge b_clk) disable iff (b_rst)
    (b_pipe && b_sel && !b_wr) ##1 1'b1 ##1 b_oe |=> b_rvalid);
  p_b_oe_gate_r10: assert property (@(posedge b_clk) disable iff (b_rst)
    !b_oe |=> !b_rvalid);
  p_b_lo_lane_zero_r6: assert property (@(posedge b_clk) disable iff (b_rst)
    !b_pipe && b_sel && !b_wr && !b_lo_en |=> ##1 b_rdata[LO_W-1:0] == '0);

  always_ff @(posedge a_clk) begin
    if (a_rst) p_reset_quiet_r1: assert (!a_rvalid && a_rdata == '0);
  end
endmodule

// File: tb/sim_dual_burst_ram.sv
module sim_dual_burst_ram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 6;
  localparam int DW = 18;
  localparam int LW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [1:0] cs0 = '0, cs1 = '0, hi = '0, lo = '0, wr = '0, oe = '0;
  logic [1:0] pm = '0, ld = '0, inc = '0, clr = '0;
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];
  logic [1:0] rv;

  dual_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .a_clk(clk), .a_rst(rst), .a_cs0(cs0[0]), .a_cs1(cs1[0]), .a_hi_en(hi[0]),
    .a_lo_en(lo[0]), .a_wr(wr[0]), .a_oe(oe[0]), .a_pipe(pm[0]), .a_ld(ld[0]),
    .a_inc(inc[0]), .a_clr(clr[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
    .a_rdata(rd[0]), .a_rvalid(rv[0]),
    .b_clk(clk), .b_rst(rst), .b_cs0(cs0[1]), .b_cs1(cs1[1]), .b_hi_en(hi[1]),
    .b_lo_en(lo[1]), .b_wr(wr[1]), .b_oe(oe[1]), .b_pipe(pm[1]), .b_ld(ld[1]),
    .b_inc(inc[1]), .b_clr(clr[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
    .b_rdata(rd[1]), .b_rvalid(rv[1]));

  // reference state
  logic [DW-1:0] mem [N];
  logic [1:0]    kn  [N];
  logic [AW-1:0] ptr [2];
  logic [AW-1:0] pad [2];
  logic [DW-1:0] pwd [2];
  logic [1:0]    pgo, pwr, phi, plo, oel, s1v, s2v;
  logic [DW-1:0] s1d [2], s2d [2], s1m [2], s2m [2];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string tag = "R1";

  function automatic logic [DW-1:0] lmask(input logic h, input logic l);
    return {{(DW-LW){h}}, {LW{l}}};
  endfunction

  task automatic chk(input bit ok, input string req, input int p,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s port%0d got %h exp %h at %0t", req, p, got, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int p = 0; p < 2; p++) begin
      ptr[p] = '0; pad[p] = '0; pwd[p] = '0;
      s1d[p] = '0; s2d[p] = '0; s1m[p] = '1; s2m[p] = '1;
    end
    pgo = '0; pwr = '0; phi = '0; plo = '0; oel = '0; s1v = '0; s2v = '0;
  endtask

  task automatic model_edge();
    logic [DW-1:0] nd [2];
    logic [DW-1:0] nm [2];
    logic [1:0] nv;
    for (int p = 0; p < 2; p++) begin
      int q = 1 - p;
      logic conf;
      logic [DW-1:0] m;
      conf  = pgo[q] && pwr[q] && (pad[q] == pad[p]);
      m     = lmask(phi[p], plo[p]);
      nv[p] = pgo[p] && !pwr[p];
      nd[p] = mem[pad[p]] & m;
      nm[p] = ~m | (conf ? '0 : lmask(kn[pad[p]][1], kn[pad[p]][0]));
    end
    for (int p = 0; p < 2; p++) begin
      s2v[p] = s1v[p]; s2d[p] = s1d[p]; s2m[p] = s1m[p];
      s1v[p] = nv[p];
      if (nv[p]) begin s1d[p] = nd[p]; s1m[p] = nm[p]; end
    end
    for (int p = 0; p < 2; p++) begin
      if (pgo[p] && pwr[p]) begin
        logic [DW-1:0] m;
        m = lmask(phi[p], plo[p]);
        mem[pad[p]] = (mem[pad[p]] & ~m) | (pwd[p] & m);
        kn[pad[p]]  = kn[pad[p]] | {phi[p], plo[p]};
      end
    end
    if (pgo[0] && pwr[0] && pgo[1] && pwr[1] && pad[0] == pad[1])
      kn[pad[0]] = kn[pad[0]] & ~({phi[0], plo[0]} | {phi[1], plo[1]});
    for (int p = 0; p < 2; p++) begin
      logic [AW-1:0] nx;
      if (clr[p])      nx = '0;
      else if (ld[p])  nx = ad[p];
      else if (inc[p]) nx = ptr[p] + 1'b1;
      else             nx = ptr[p];
      ptr[p] = nx; pad[p] = nx;
      pgo[p] = cs0[p] & cs1[p]; pwr[p] = wr[p]; phi[p] = hi[p]; plo[p] = lo[p];
      pwd[p] = wd[p]; oel[p] = oe[p];
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      logic ev;
      logic [DW-1:0] ed, em;
      string lat;
      lat = pm[p] ? "R3" : "R2";
      ev  = (pm[p] ? s2v[p] : s1v[p]) & oel[p];
      ed  = pm[p] ? s2d[p] : s1d[p];
      em  = pm[p] ? s2m[p] : s1m[p];
      chk(rv[p] == ev, {lat, "/", tag, " rvalid"}, p, DW'(rv[p]), DW'(ev));
      chk(((rd[p] ^ ed) & em) == '0, {tag, " rdata"}, p, rd[p], ed);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_edge();
    compare();
  endtask

  task automatic drv(input int p, input bit s, input bit w, input bit h, input bit l,
                     input bit o, input bit c, input bit lq, input bit iq,
                     input int a, input int d);
    cs0[p] = s; cs1[p] = s; wr[p] = w; hi[p] = h; lo[p] = l; oe[p] = o;
    clr[p] = c; ld[p] = lq; inc[p] = iq; ad[p] = a[AW-1:0]; wd[p] = d[DW-1:0];
  endtask

  task automatic idle(input int p);
    drv(p, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit apipe, input bit bpipe);
    idle(0); idle(1);
    rst = 1'b1;
    pm  = {bpipe, apipe};
    @(posedge clk);
    #1;
    tag = "R1";
    for (int p = 0; p < 2; p++) begin
      chk(rv[p] == 1'b0, "R1 rvalid in reset", p, DW'(rv[p]), '0);
      chk(rd[p] == '0, "R1 rdata in reset", p, rd[p], '0);
    end
    clear_model();
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic rand_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      for (int p = 0; p < 2; p++) begin
        drv(p, ($urandom % 8) != 0, ($urandom % 5) < 2, ($urandom % 4) != 0,
            ($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 20) == 0,
            ($urandom % 3) == 0, ($urandom % 2) == 0, int'($urandom % N),
            int'($urandom));
        if (($urandom % 16) == 0) cs1[p] = 1'b0;
      end
      cyc();
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) begin mem[i] = '0; kn[i] = 2'b00; end
    ad[0] = '0; ad[1] = '0; wd[0] = '0; wd[1] = '0;
    clear_model();
    #1;
    do_reset(1'b0, 1'b1);

    tag = "R9"; // cross-port and same-port visibility
    drv(0, 1, 1, 1, 1, 1, 0, 1, 0, 3, 'h2AB5); idle(1); cyc();
    idle(0); cyc();
    drv(1, 1, 0, 1, 1, 1, 0, 1, 0, 3, 0); cyc();
    idle(1); cyc(); cyc(); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 1, 0, 3, 0); cyc();
    idle(0); cyc();

    tag = "R5"; // upper lane only write
    drv(0, 1, 1, 1, 0, 1, 0, 1, 0, 3, 'h3FFFF); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0); cyc();
    idle(0); cyc();

    tag = "R6"; // lane-masked reads
    drv(0, 1, 0, 0, 1, 1, 0, 1, 0, 3, 0); cyc();
    drv(0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0); cyc();
    idle(0); cyc();

    tag = "R7"; // pointer priority
    drv(0, 1, 1, 1, 1, 1, 0, 1, 0, 10, 'h111); cyc();
    drv(0, 1, 1, 1, 1, 1, 0, 0, 1, 0, 'h222); cyc();
    drv(0, 1, 1, 1, 1, 1, 1, 1, 1, 20, 'h333); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 1, 1, 10, 0); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0); cyc();
    drv(0, 1, 0, 1, 1, 1, 1, 0, 0, 0, 0); cyc();
    idle(0); cyc();

    tag = "R8"; // wrap from last word
    drv(0, 1, 1, 1, 1, 1, 0, 1, 0, N - 1, 'h15A5A); cyc();
    drv(0, 1, 1, 1, 1, 1, 0, 0, 1, 0, 'h0F0F0); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 1, 0, N - 1, 0); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0); cyc();
    idle(0); cyc();

    tag = "R4"; // half-selected port does nothing
    drv(0, 1, 1, 1, 1, 1, 0, 1, 0, 3, 'h12345); cs1[0] = 1'b0; cyc();
    drv(0, 1, 1, 1, 1, 1, 0, 1, 0, 3, 'h0BEEF); cs0[0] = 1'b0; cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 1, 0, 3, 0); cyc();
    drv(0, 1, 0, 1, 1, 1, 0, 1, 0, 10, 0); cs0[0] = 1'b0; cyc();
    idle(0); cyc();

    tag = "R10"; // output enable gates only the flag
    drv(0, 1, 0, 1, 1, 0, 0, 1, 0, 10, 0); cyc();
    drv(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0); cyc();
    drv(1, 1, 0, 1, 1, 0, 0, 1, 0, 20, 0); cyc();
    drv(1, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); cyc();
    drv(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0); cyc();
    idle(0); idle(1); cyc();

    tag = "R11"; // writes raise no valid
    drv(1, 1, 1, 1, 1, 1, 0, 1, 0, 40, 'h2F00F); cyc();
    drv(1, 1, 1, 1, 1, 1, 0, 0, 1, 0, 'h10FF0); cyc();
    idle(1); cyc(); cyc();

    tag = "R3"; // pipelined burst read on port B
    drv(1, 1, 0, 1, 1, 1, 0, 1, 0, 40, 0); cyc();
    drv(1, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0); cyc();
    idle(1); cyc(); cyc();

    tag = "R9";
    rand_run(1500);

    do_reset(1'b1, 1'b0);
    tag = "R2"; // flow-through burst on port B
    drv(1, 1, 1, 1, 1, 1, 0, 1, 0, 50, 'h0ACE1); cyc();
    drv(1, 1, 0, 1, 1, 1, 0, 1, 0, 50, 0); cyc();
    idle(1); cyc(); cyc();
    tag = "R9";
    rand_run(1500);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule